// File: doc/BRIEF.md
# Adaptive Supply Step Controller

This block sits between an adaptive voltage sensor and a supply regulator. The sensor raises a six-bit vector of event flags and a result word whose error-step field says how many regulator steps the supply is off. The controller picks one flag by fixed priority. It filters weak recommendations against a per-direction threshold plus margin. It turns a valid up or down recommendation into a clamped voltage request, waits for the regulator to accept or refuse it, and then answers the sensor. The answer is a clear of all flags together with exactly one accept pulse or one reject pulse.

The controller also tracks two saturation conditions. When an up request lands on the ceiling, later up recommendations are refused until a down step succeeds. When a down request would reach or pass the floor, and no operating-mode change is flagged, the controller starts refusing down events on its own. In that state it drops the down-interrupt enable, and it leaves this state only after the next successful up step. The controller does not look at the flag vector again until the current regulator handshake has finished.

Top module: `vrec_ctrl`

## Requirements
- R1: Flags are served by fixed priority: up (bit 4) first, then down (bit 2), then min (bit 1), then max (bit 5). The mid flag (bit 3) and bit 0 never start any action.
- R2: While `auto_nack_dn` is high, the down flag is not served. A lone down flag gives no pulse and no request, while a lower-priority flag raised with it is served.
- R3: The error step is bits [5:2] of `result_word`. An up or down recommendation whose step is below that direction's threshold plus margin is refused with `irq_clr` and `nack_pulse`, and no request is made. A step equal to threshold plus margin is accepted.
- R4: The up target is `cur_volt + step*step_size`, capped at `vmax`. A successful up step that lands exactly on `vmax` makes every later up recommendation be refused (clear plus NACK, no request).
- R5: The down target is `cur_volt - step*step_size`, raised to `vmin` when the result is at or below it. A successful down step lifts the ceiling lock of R4.
- R6: A successful up step pulses `irq_clr` and `ack_pulse` in the same cycle. The same step forces `auto_nack_dn` low and `dn_irq_en` high.
- R7: When an accepted down step has an uncapped result at or below `vmin` and `mode_chg` was low when the step was taken, its ACK cycle sets `auto_nack_dn` high and `dn_irq_en` low. When `mode_chg` was high, both are left unchanged.
- R8: A served min or max flag only pulses `irq_clr` and `nack_pulse`. A mid flag alone causes no pulse.
- R9: If the regulator reports failure (`vreq_fail` high with `vreq_ready`), the controller pulses `irq_clr` and `nack_pulse` with no ACK, and the saturation state is unchanged.
- R10: Every served event gives exactly one of ACK or NACK. A request holds `vreq_valid` and a stable `vreq_volt` until `vreq_ready`. The response follows one cycle after a decision or a handshake.
- R11: After reset there is no request and no pulse, `dn_irq_en` is high and `auto_nack_dn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_flags | input | 6 | Sensor event flags (level) |
| result_word | input | RW | Sensor result, error step in bits [5:2] |
| cur_volt | input | VW | Present supply voltage, in regulator units |
| up_thr | input | THW | Up threshold |
| up_margin | input | THW | Up margin |
| dn_thr | input | THW | Down threshold |
| dn_margin | input | THW | Down margin |
| step_size | input | SSW | Voltage units per error step |
| vmin | input | VW | Present floor |
| vmax | input | VW | Present ceiling |
| mode_chg | input | 1 | Operating mode changed since the last event |
| vreq_valid | output | 1 | Voltage request pending |
| vreq_volt | output | VW | Requested voltage |
| vreq_ready | input | 1 | Regulator finished the request |
| vreq_fail | input | 1 | Regulator could not apply the request (with ready) |
| ack_pulse | output | 1 | One-cycle accept of the recommendation |
| nack_pulse | output | 1 | One-cycle reject of the recommendation |
| irq_clr | output | 1 | One-cycle clear of all six flags |
| dn_irq_en | output | 1 | Down-interrupt enable |
| auto_nack_dn | output | 1 | Automatic down-reject control |

## Verification
The up path is run in three ways: with steps that stay below the ceiling, with steps that overshoot and are capped, and with a step at exactly threshold plus margin. These runs separate the clamp, the ceiling lock and the filter boundary. The down path is tried with the uncapped result above the floor, exactly on it and below it, each with and without a mode change, which shows whether saturation starts only under the documented conditions. Mixed flag vectors, such as up with down, min with max and mid, and down while saturated, expose the priority order and the down mask. Regulator delays and failures check that the request is held and that a failure leaves the saturation state untouched.

// File: rtl/vrec_pkg.sv
package vrec_pkg;
    localparam int NFLAG     = 6;
    localparam int BIT_MIN   = 1;
    localparam int BIT_DN    = 2;
    localparam int BIT_MID   = 3;
    localparam int BIT_UP    = 4;
    localparam int BIT_MAX   = 5;
    localparam int ESTEP_LSB = 2;

    typedef enum logic [2:0] {
        EV_NONE, EV_UP, EV_DN, EV_MIN, EV_MAX, EV_MID
    } ev_e;

    typedef enum logic {
        ST_IDLE, ST_WAIT
    } st_e;
endpackage

// File: rtl/vrec_flag_pick.sv
module vrec_flag_pick
    import vrec_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    input  logic             auto_dn,
    output ev_e              ev
);
    always_comb begin
        if (flags[BIT_UP])                 ev = EV_UP;
        else if (flags[BIT_DN] && !auto_dn) ev = EV_DN;
        else if (flags[BIT_MIN])           ev = EV_MIN;
        else if (flags[BIT_MAX])           ev = EV_MAX;
        else if (flags[BIT_MID])           ev = EV_MID;
        else                               ev = EV_NONE;
    end
endmodule

// File: rtl/vrec_step_math.sv
module vrec_step_math #(
    parameter int VW     = 16,
    parameter int ESW    = 4,
    parameter int THW    = 4,
    parameter int SSW    = 8,
    parameter bit UP_DIR = 1'b1
) (
    input  logic [ESW-1:0] err_step,
    input  logic [THW-1:0] thr,
    input  logic [THW-1:0] marg,
    input  logic [VW-1:0]  cur,
    input  logic [SSW-1:0] step,
    input  logic [VW-1:0]  vmin,
    input  logic [VW-1:0]  vmax,
    output logic           pass,
    output logic [VW-1:0]  target,
    output logic           at_limit
);
    localparam int PW = ESW + SSW;
    localparam int SW = ((VW > PW) ? VW : PW) + 2;
    localparam int CW = (ESW > THW + 1) ? ESW : THW + 1;

    logic [PW-1:0]        delta;
    logic signed [SW-1:0] raw;
    logic signed [SW-1:0] lim_s;

    always_comb begin
        pass  = CW'(err_step) >= (CW'(thr) + CW'(marg));
        delta = PW'(err_step) * PW'(step);
    end

    generate
        if (UP_DIR) begin : g_up
            always_comb begin
                raw   = $signed(SW'(cur)) + $signed(SW'(delta));
                lim_s = $signed(SW'(vmax));
                target   = (raw >= lim_s) ? vmax : raw[VW-1:0];
                at_limit = (target == vmax);
            end
        end else begin : g_dn
            always_comb begin
                raw   = $signed(SW'(cur)) - $signed(SW'(delta));
                lim_s = $signed(SW'(vmin));
                at_limit = (raw <= lim_s);
                target   = at_limit ? vmin : raw[VW-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/vrec_ctrl.sv
module vrec_ctrl
    import vrec_pkg::*;
#(
    parameter int VW  = 16,
    parameter int ESW = 4,
    parameter int THW = 4,
    parameter int SSW = 8,
    parameter int RW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] irq_flags,
    input  logic [RW-1:0]    result_word,
    input  logic [VW-1:0]    cur_volt,
    input  logic [THW-1:0]   up_thr,
    input  logic [THW-1:0]   up_margin,
    input  logic [THW-1:0]   dn_thr,
    input  logic [THW-1:0]   dn_margin,
    input  logic [SSW-1:0]   step_size,
    input  logic [VW-1:0]    vmin,
    input  logic [VW-1:0]    vmax,
    input  logic             mode_chg,
    output logic             vreq_valid,
    output logic [VW-1:0]    vreq_volt,
    input  logic             vreq_ready,
    input  logic             vreq_fail,
    output logic             ack_pulse,
    output logic             nack_pulse,
    output logic             irq_clr,
    output logic             dn_irq_en,
    output logic             auto_nack_dn
);
    localparam int ES_MSB = ESTEP_LSB + ESW - 1;

    typedef struct packed {
        st_e           st;
        logic          dir_up;
        logic          hit_max;
        logic          floor_hit;
        logic          at_max;
        logic          auto_dn;
        logic          dn_en;
        logic          req_v;
        logic [VW-1:0] req_volt;
        logic          ack;
        logic          nack;
        logic          clr;
    } state_t;

    state_t s_d, s_q;
    ev_e    ev;

    logic [ESW-1:0] err_step;
    logic           up_pass, dn_pass;
    logic [VW-1:0]  up_tgt, dn_tgt;
    logic           up_ceil, dn_floor;
    logic           unused_bits;

    assign err_step = result_word[ES_MSB:ESTEP_LSB];

    generate
        if (RW > ES_MSB + 1) begin : g_res_hi
            assign unused_bits = ^{irq_flags[0], result_word[RW-1:ES_MSB+1],
                                   result_word[ESTEP_LSB-1:0]};
        end else begin : g_res_lo
            assign unused_bits = ^{irq_flags[0], result_word[ESTEP_LSB-1:0]};
        end
    endgenerate

    vrec_flag_pick u_pick (
        .flags   (irq_flags),
        .auto_dn (s_q.auto_dn),
        .ev      (ev)
    );

    vrec_step_math #(.VW(VW), .ESW(ESW), .THW(THW), .SSW(SSW), .UP_DIR(1'b1)) u_up (
        .err_step (err_step),
        .thr      (up_thr),
        .marg     (up_margin),
        .cur      (cur_volt),
        .step     (step_size),
        .vmin     (vmin),
        .vmax     (vmax),
        .pass     (up_pass),
        .target   (up_tgt),
        .at_limit (up_ceil)
    );

    vrec_step_math #(.VW(VW), .ESW(ESW), .THW(THW), .SSW(SSW), .UP_DIR(1'b0)) u_dn (
        .err_step (err_step),
        .thr      (dn_thr),
        .marg     (dn_margin),
        .cur      (cur_volt),
        .step     (step_size),
        .vmin     (vmin),
        .vmax     (vmax),
        .pass     (dn_pass),
        .target   (dn_tgt),
        .at_limit (dn_floor)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        s_d.nack = 1'b0;
        s_d.clr  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                unique case (ev)
                    EV_UP: begin
                        if (s_q.at_max || !up_pass) begin
                            s_d.clr  = 1'b1;
                            s_d.nack = 1'b1;
                        end else begin
                            s_d.st       = ST_WAIT;
                            s_d.req_v    = 1'b1;
                            s_d.req_volt = up_tgt;
                            s_d.dir_up   = 1'b1;
                            s_d.hit_max  = up_ceil;
                        end
                    end
                    EV_DN: begin
                        if (!dn_pass) begin
                            s_d.clr  = 1'b1;
                            s_d.nack = 1'b1;
                        end else begin
                            s_d.st        = ST_WAIT;
                            s_d.req_v     = 1'b1;
                            s_d.req_volt  = dn_tgt;
                            s_d.dir_up    = 1'b0;
                            s_d.floor_hit = dn_floor && !mode_chg;
                        end
                    end
                    EV_MIN, EV_MAX: begin
                        s_d.clr  = 1'b1;
                        s_d.nack = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_WAIT: begin
                if (vreq_ready) begin
                    s_d.st    = ST_IDLE;
                    s_d.req_v = 1'b0;
                    s_d.clr   = 1'b1;
                    if (vreq_fail) begin
                        s_d.nack = 1'b1;
                    end else begin
                        s_d.ack = 1'b1;
                        if (s_q.dir_up) begin
                            s_d.at_max  = s_q.hit_max;
                            s_d.auto_dn = 1'b0;
                            s_d.dn_en   = 1'b1;
                        end else begin
                            s_d.at_max = 1'b0;
                            if (s_q.floor_hit) begin
                                s_d.auto_dn = 1'b1;
                                s_d.dn_en   = 1'b0;
                            end
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.dn_en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign vreq_valid   = s_q.req_v;
    assign vreq_volt    = s_q.req_volt;
    assign ack_pulse    = s_q.ack;
    assign nack_pulse   = s_q.nack;
    assign irq_clr      = s_q.clr;
    assign dn_irq_en    = s_q.dn_en;
    assign auto_nack_dn = s_q.auto_dn;
endmodule

// File: rtl/vrec_ctrl_chk.sv
module vrec_ctrl_chk #(
    parameter int VW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [VW-1:0] vmin,
    input logic [VW-1:0] vmax,
    input logic          vreq_valid,
    input logic [VW-1:0] vreq_volt,
    input logic          vreq_ready,
    input logic          vreq_fail,
    input logic          ack_pulse,
    input logic          nack_pulse,
    input logic          irq_clr,
    input logic          dn_irq_en,
    input logic          auto_nack_dn
);
    assert_one_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_pulse && nack_pulse));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> irq_clr);

    assert_nack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nack_pulse |-> irq_clr);

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vreq_valid && !vreq_ready) |=> (vreq_valid && $stable(vreq_volt)));

    // R5: the floor bound is checked together with the ceiling
    assert_req_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vreq_valid |-> (vreq_volt <= vmax && vreq_volt >= vmin));

    assert_fail_rejects_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vreq_valid && vreq_ready && vreq_fail) |=> (nack_pulse && !ack_pulse));

    assert_done_accepts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vreq_valid && vreq_ready && !vreq_fail) |=> (ack_pulse && !nack_pulse));

    assert_sat_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        auto_nack_dn |-> !dn_irq_en);
endmodule

bind vrec_ctrl vrec_ctrl_chk #(.VW(VW)) u_chk (.*);

// File: tb/vrec_ctrl_bench.sv
`timescale 1ns/1ps
module vrec_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  flags;
    logic [31:0] result;
    logic [15:0] cur, vmin, vmax;
    logic [3:0]  uthr, umar, dthr, dmar;
    logic [7:0]  step;
    logic        mchg, vready, vfail;
    logic        vreq_valid, ack_pulse, nack_pulse, irq_clr, dn_irq_en, auto_nack_dn;
    logic [15:0] vreq_volt;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit run_cmp = 0;
    string cur_tag = "R11";

    always #4 clk = ~clk;

    vrec_ctrl u_vrec_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_flags(flags), .result_word(result),
        .cur_volt(cur), .up_thr(uthr), .up_margin(umar), .dn_thr(dthr),
        .dn_margin(dmar), .step_size(step), .vmin(vmin), .vmax(vmax),
        .mode_chg(mchg), .vreq_valid(vreq_valid), .vreq_volt(vreq_volt),
        .vreq_ready(vready), .vreq_fail(vfail), .ack_pulse(ack_pulse),
        .nack_pulse(nack_pulse), .irq_clr(irq_clr), .dn_irq_en(dn_irq_en),
        .auto_nack_dn(auto_nack_dn)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    bit m_wait, m_dirup, m_hitmax, m_floor, m_atmax, m_auto, m_dnen;
    bit m_req, m_ack, m_nack, m_clr;
    int m_volt, es, dlt, raw;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wait = 0; m_dirup = 0; m_hitmax = 0; m_floor = 0; m_atmax = 0;
            m_auto = 0; m_dnen = 1; m_req = 0; m_volt = 0;
            m_ack = 0; m_nack = 0; m_clr = 0;
        end else begin
            m_ack = 0; m_nack = 0; m_clr = 0;
            es  = (result >> 2) & 15;
            dlt = es * step;
            if (!m_wait) begin
                if (flags[4]) begin
                    if (m_atmax || es < uthr + umar) begin
                        m_clr = 1; m_nack = 1;
                    end else begin
                        raw = cur + dlt;
                        m_volt = (raw >= vmax) ? vmax : raw;
                        m_hitmax = (m_volt == vmax);
                        m_req = 1; m_wait = 1; m_dirup = 1;
                    end
                end else if (flags[2] && !m_auto) begin
                    if (es < dthr + dmar) begin
                        m_clr = 1; m_nack = 1;
                    end else begin
                        raw = cur - dlt;
                        m_volt = (raw <= vmin) ? vmin : raw;
                        m_floor = (raw <= vmin) && !mchg;
                        m_req = 1; m_wait = 1; m_dirup = 0;
                    end
                end else if (flags[1] || flags[5]) begin
                    m_clr = 1; m_nack = 1;
                end
            end else if (m_req && vready) begin
                m_req = 0; m_wait = 0; m_clr = 1;
                if (vfail) m_nack = 1;
                else begin
                    m_ack = 1;
                    if (m_dirup) begin
                        m_atmax = m_hitmax; m_auto = 0; m_dnen = 1;
                    end else begin
                        m_atmax = 0;
                        if (m_floor) begin m_auto = 1; m_dnen = 0; end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            check(vreq_valid == m_req, cur_tag, "vreq_valid", vreq_valid, m_req);
            if (m_req) check(vreq_volt == m_volt, cur_tag, "vreq_volt", vreq_volt, m_volt);
            check(ack_pulse == m_ack, cur_tag, "ack", ack_pulse, m_ack);
            check(nack_pulse == m_nack, cur_tag, "nack", nack_pulse, m_nack);
            check(irq_clr == m_clr, cur_tag, "clr", irq_clr, m_clr);
            check(dn_irq_en == m_dnen, cur_tag, "dn_irq_en", dn_irq_en, m_dnen);
            check(auto_nack_dn == m_auto, cur_tag, "auto_nack_dn", auto_nack_dn, m_auto);
        end
    end

    // one event: drive flags and result, play regulator, collect the answer
    task automatic evt(input logic [5:0] st, input int e, input int cv, input int dly,
                       input bit fl, input bit mc, input string tg,
                       input bit x_ack, input bit x_nack, input bit x_req, input int x_volt);
        bit got_ack, got_nack, got_req, done;
        int volt, n;
        cur_tag = tg;
        got_ack = 0; got_nack = 0; got_req = 0; done = 0; volt = 0; n = 0;
        @(negedge clk);
        flags  = st;
        result = (32'hA5A5A5A5 & ~32'h3C) | (32'(e) << 2);
        cur    = 16'(cv);
        mchg   = mc;
        while (!done && n < 12) begin
            @(negedge clk);
            n++;
            if (ack_pulse)  got_ack = 1;
            if (nack_pulse) got_nack = 1;
            if (irq_clr) begin flags = 6'h00; done = 1; end
            if (vreq_valid) begin
                got_req = 1; volt = vreq_volt;
                if (n > dly) begin vready = 1; vfail = fl; end
            end else begin
                vready = 0; vfail = 0;
            end
        end
        flags = 6'h00; vready = 0; vfail = 0;
        @(negedge clk);
        check(got_ack == x_ack, tg, "ack seen", got_ack, x_ack);
        check(got_nack == x_nack, tg, "nack seen", got_nack, x_nack);
        check(got_req == x_req, tg, "request seen", got_req, x_req);
        if (x_req) check(volt == x_volt, tg, "request volt", volt, x_volt);
    endtask

    task automatic sat(input string tg, input bit x_auto, input bit x_en);
        check(auto_nack_dn == x_auto, tg, "auto_nack_dn", auto_nack_dn, x_auto);
        check(dn_irq_en == x_en, tg, "dn_irq_en", dn_irq_en, x_en);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R10 act=%0d exp=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 0; flags = 0; result = 0; cur = 16'd1100; vmin = 16'd1000; vmax = 16'd1200;
        uthr = 4'd2; umar = 4'd1; dthr = 4'd1; dmar = 4'd1; step = 8'd10;
        mchg = 0; vready = 0; vfail = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(vreq_valid == 0, "R11", "vreq_valid", vreq_valid, 0);
        check(ack_pulse == 0 && nack_pulse == 0 && irq_clr == 0, "R11", "pulses",
              {ack_pulse, nack_pulse, irq_clr}, 0);
        sat("R11", 0, 1);
        rst_n = 1;
        run_cmp = 1;
        @(negedge clk);

        evt(6'h10, 5, 1100, 0, 0, 0, "R6", 1, 0, 1, 1150);   sat("R6", 0, 1);
        evt(6'h10, 8, 1150, 0, 0, 0, "R4", 1, 0, 1, 1200);
        evt(6'h10, 8, 1200, 0, 0, 0, "R4", 0, 1, 0, 0);      // ceiling lock
        evt(6'h04, 4, 1200, 1, 0, 0, "R5", 1, 0, 1, 1160);
        evt(6'h10, 3, 1160, 0, 0, 0, "R3", 1, 0, 1, 1190);   // gate boundary, lock lifted (R5)
        evt(6'h10, 2, 1190, 0, 0, 0, "R3", 0, 1, 0, 0);
        evt(6'h04, 1, 1190, 0, 0, 0, "R3", 0, 1, 0, 0);
        evt(6'h04, 5, 1030, 0, 0, 0, "R7", 1, 0, 1, 1000);   sat("R7", 1, 0);
        evt(6'h04, 5, 1100, 0, 0, 0, "R2", 0, 0, 0, 0);      sat("R2", 1, 0);
        evt(6'h06, 5, 1100, 0, 0, 0, "R2", 0, 1, 0, 0);
        evt(6'h14, 3, 1000, 0, 0, 0, "R1", 1, 0, 1, 1030);   sat("R6", 0, 1);
        evt(6'h04, 2, 1010, 0, 0, 1, "R7", 1, 0, 1, 1000);   sat("R7", 0, 1);
        evt(6'h04, 2, 1020, 0, 0, 0, "R7", 1, 0, 1, 1000);   sat("R7", 1, 0);
        evt(6'h10, 4, 1000, 0, 0, 0, "R6", 1, 0, 1, 1040);   sat("R6", 0, 1);
        evt(6'h20, 4, 1040, 0, 0, 0, "R8", 0, 1, 0, 0);
        evt(6'h08, 4, 1040, 0, 0, 0, "R8", 0, 0, 0, 0);
        evt(6'h2A, 4, 1040, 0, 0, 0, "R1", 0, 1, 0, 0);
        evt(6'h10, 5, 1190, 2, 1, 0, "R9", 0, 1, 1, 1200);
        evt(6'h10, 5, 1190, 4, 0, 0, "R10", 1, 0, 1, 1200);  // lock not set by failure (R9)
        evt(6'h30, 5, 1190, 0, 0, 0, "R4", 0, 1, 0, 0);
        evt(6'h04, 2, 1100, 0, 1, 0, "R9", 0, 1, 1, 1080);
        evt(6'h10, 5, 1100, 0, 0, 0, "R9", 0, 1, 0, 0);      // failed down kept the lock
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule